// File: doc/BRIEF.md
# Write-Protected Media-Interface Converter Configuration Bank

This block is the register bank of a five-port media-interface converter. Software reaches it over a simple 32-bit bus with an address, a write strobe with write data, and a read strobe with registered read data. The bank holds a global switch-mode value, one control word per converter port, a per-port converter release word and two switch override words. Their fields come out as static configuration signals for the converter datapath and the switch.

The switch-mode word is protected. A write to it lands only after software has written a fixed four-word key to the command register at offset 0x0. Until then, writes to the mode word are dropped and a sticky error flag is raised. Once the key has been accepted, the bank stays unlocked until reset. Every writable field reads back exactly what was last written, so software can do read-modify-write updates. The per-port link, duplex and speed status of the RGMII receiver are read live from input pins.

Top module: `cvt_cfg_bank`

## Requirements
- R1: After reset every register is 0. That means every port converter is held in reset, the bank is locked, `lock_err_o` is 0 and all configuration outputs are 0.
- R2: Four consecutive command writes (offset 0x0) of the 32-bit values 0x000000A5, 0x00000001, 0x0000FFFE and 0x00000001, in that order, unlock the bank. A write to the mode word in the cycle after the fourth key write already lands. The bank stays unlocked until the next reset.
- R3: A command write whose value is not the next expected key word sends the key tracker back to its start. Writes to other offsets that come between key words do not disturb the tracker.
- R4: While the bank is locked, a write to the mode word (offset 0x20) leaves it unchanged and sets `lock_err_o`. `lock_err_o` stays 1 until reset.
- R5: The mode word at offset 0x20 holds a 5-bit switch mode in bits [4:0]. It drives `sw_mode_o` one cycle after an accepted write and reads back with all other bits 0.
- R6: Port p (0 to 4) has a control word at 0x100 + 4*p. Its writable fields are:
  - bits [1:0], speed (0 = 10 Mb/s, 1 = 100 Mb/s, 2 = 1000 Mb/s);
  - bits [3:2], interface (0 = MII, 1 = RMII, 2 = RGMII);
  - bit 8, full duplex.

  These fields appear on `port_speed_o[2p+1:2p]`, `port_if_o[2p+1:2p]` and `port_fdx_o[p]` one cycle after the write, and read back as written.
- R7: In a port control word, bit 12 reads `rgmii_link_i[p]`, bit 13 reads `rgmii_dup_i[p]` and bits [15:14] read `rgmii_spd_i[2p+1:2p]`. Writes to those bits are ignored. All other unlisted bits read 0.
- R8: The release word at 0x114 holds one bit per port in bits [4:0]. A 1 releases that port's converter, a 0 holds it in reset. It drives `port_run_o` one cycle after a write.
- R9: The switch speed override word at 0x304 and the duplex override word at 0x308 each hold bits [4:0]. They drive `sw_spd_ovr_o` and `sw_dup_ovr_o`. A value of 0 leaves speed and duplex to the switch.
- R10: `rdata_o` is loaded one cycle after `rd_i` with the word at `addr_i` and holds between reads. The command register and all unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| rgmii_link_i | input | 5 | Per-port RGMII link status |
| rgmii_dup_i | input | 5 | Per-port RGMII duplex status |
| rgmii_spd_i | input | 10 | Per-port RGMII speed status, 2 bits per port |
| sw_mode_o | output | 5 | Switch mode |
| port_speed_o | output | 10 | Per-port speed, 2 bits per port |
| port_if_o | output | 10 | Per-port interface type, 2 bits per port |
| port_fdx_o | output | 5 | Per-port full duplex |
| port_run_o | output | 5 | Per-port converter release |
| sw_spd_ovr_o | output | 5 | Switch speed override |
| sw_dup_ovr_o | output | 5 | Switch duplex override |
| lock_err_o | output | 1 | Sticky flag: a write to the mode word was dropped while locked |

## Verification
Every stored field, the unlock state and the error flag change on the clock edge that samples the write strobe. The read word appears on `rdata_o` on the edge that samples `rd_i`. So each result is due one cycle after its stimulus. The bench drives strobes for exactly one cycle starting at a falling edge and samples at the next falling edge, which lies half a period after the updating edge. The key tests check that the first mode write after the fourth key word lands with no extra delay, and that mismatched or interleaved writes are judged only by the command-register write order.

// File: rtl/cvt_cfg_pkg.sv
package cvt_cfg_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned MODE_W   = 5;
  localparam int unsigned OFF_CMD  = 'h000;
  localparam int unsigned OFF_MODE = 'h020;
  localparam int unsigned OFF_PORT = 'h100;
  localparam int unsigned OFF_RUN  = 'h114;
  localparam int unsigned OFF_SSPD = 'h304;
  localparam int unsigned OFF_SDUP = 'h308;

  localparam logic [DATA_W-1:0] KEY0 = 32'h0000_00A5;
  localparam logic [DATA_W-1:0] KEY1 = 32'h0000_0001;
  localparam logic [DATA_W-1:0] KEY2 = 32'h0000_FFFE;
  localparam logic [DATA_W-1:0] KEY3 = 32'h0000_0001;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_K1, SEQ_K2, SEQ_K3} seq_e;

  typedef struct packed {
    logic [1:0] speed;
    logic [1:0] ifmode;
    logic       fdx;
  } port_cfg_t;
endpackage

// File: rtl/cvt_unlock_seq.sv
module cvt_unlock_seq
  import cvt_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              unlocked_o
);
  seq_e st_q;
  logic unl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SEQ_IDLE;
      unl_q <= 1'b0;
    end else if (cmd_wr_i && !unl_q) begin
      unique case (st_q)
        SEQ_IDLE: st_q <= (wdata_i == KEY0) ? SEQ_K1 : SEQ_IDLE;
        SEQ_K1:   st_q <= (wdata_i == KEY1) ? SEQ_K2 : SEQ_IDLE;
        SEQ_K2:   st_q <= (wdata_i == KEY2) ? SEQ_K3 : SEQ_IDLE;
        SEQ_K3: begin
          st_q  <= SEQ_IDLE;
          unl_q <= (wdata_i == KEY3);
        end
        default:  st_q <= SEQ_IDLE;
      endcase
    end
  end

  assign unlocked_o = unl_q;
endmodule

// File: rtl/cvt_port_reg.sv
module cvt_port_reg
  import cvt_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              link_i,
  input  logic              dup_i,
  input  logic [1:0]        spd_i,
  output port_cfg_t         cfg_o,
  output logic [DATA_W-1:0] word_o
);
  port_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (wr_i) begin
      cfg_q.speed  <= wdata_i[1:0];
      cfg_q.ifmode <= wdata_i[3:2];
      cfg_q.fdx    <= wdata_i[8];
    end
  end

  assign cfg_o  = cfg_q;
  // status bits come straight from the pins
  assign word_o = {16'b0, spd_i, dup_i, link_i, 3'b0, cfg_q.fdx, 4'b0,
                   cfg_q.ifmode, cfg_q.speed};
endmodule

// File: rtl/cvt_cfg_bank.sv
module cvt_cfg_bank
  import cvt_cfg_pkg::*;
#(
  parameter int unsigned NPORT  = 5,
  parameter int unsigned ADDR_W = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                rd_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NPORT-1:0]    rgmii_link_i,
  input  logic [NPORT-1:0]    rgmii_dup_i,
  input  logic [2*NPORT-1:0]  rgmii_spd_i,
  output logic [MODE_W-1:0]   sw_mode_o,
  output logic [2*NPORT-1:0]  port_speed_o,
  output logic [2*NPORT-1:0]  port_if_o,
  output logic [NPORT-1:0]    port_fdx_o,
  output logic [NPORT-1:0]    port_run_o,
  output logic [NPORT-1:0]    sw_spd_ovr_o,
  output logic [NPORT-1:0]    sw_dup_ovr_o,
  output logic                lock_err_o
);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFF_CMD);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFF_MODE);
  localparam logic [ADDR_W-1:0] A_RUN  = ADDR_W'(OFF_RUN);
  localparam logic [ADDR_W-1:0] A_SSPD = ADDR_W'(OFF_SSPD);
  localparam logic [ADDR_W-1:0] A_SDUP = ADDR_W'(OFF_SDUP);

  function automatic logic [ADDR_W-1:0] port_addr(int unsigned p);
    return ADDR_W'(OFF_PORT + 4 * p);
  endfunction

  logic                unlocked;
  logic [MODE_W-1:0]   mode_q;
  logic                err_q;
  logic [NPORT-1:0]    run_q, sspd_q, sdup_q;
  logic [DATA_W-1:0]   port_word [NPORT];
  logic [DATA_W-1:0]   rd_val;

  cvt_unlock_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_wr_i   (wr_i && addr_i == A_CMD),
    .wdata_i    (wdata_i),
    .unlocked_o (unlocked)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    port_cfg_t cfg;
    cvt_port_reg u_port (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_i && addr_i == port_addr(p)),
      .wdata_i (wdata_i),
      .link_i  (rgmii_link_i[p]),
      .dup_i   (rgmii_dup_i[p]),
      .spd_i   (rgmii_spd_i[2*p +: 2]),
      .cfg_o   (cfg),
      .word_o  (port_word[p])
    );
    assign port_speed_o[2*p +: 2] = cfg.speed;
    assign port_if_o[2*p +: 2]    = cfg.ifmode;
    assign port_fdx_o[p]          = cfg.fdx;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      err_q  <= 1'b0;
      run_q  <= '0;
      sspd_q <= '0;
      sdup_q <= '0;
    end else if (wr_i) begin
      if (addr_i == A_MODE) begin
        if (unlocked) mode_q <= wdata_i[MODE_W-1:0];
        else          err_q  <= 1'b1;
      end
      if (addr_i == A_RUN)  run_q  <= wdata_i[NPORT-1:0];
      if (addr_i == A_SSPD) sspd_q <= wdata_i[NPORT-1:0];
      if (addr_i == A_SDUP) sdup_q <= wdata_i[NPORT-1:0];
    end
  end

  always_comb begin
    rd_val = '0;
    if (addr_i == A_MODE) rd_val = DATA_W'(mode_q);
    if (addr_i == A_RUN)  rd_val = DATA_W'(run_q);
    if (addr_i == A_SSPD) rd_val = DATA_W'(sspd_q);
    if (addr_i == A_SDUP) rd_val = DATA_W'(sdup_q);
    for (int unsigned p = 0; p < NPORT; p++)
      if (addr_i == port_addr(p)) rd_val = port_word[p];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_val;
  end

  assign sw_mode_o    = mode_q;
  assign port_run_o   = run_q;
  assign sw_spd_ovr_o = sspd_q;
  assign sw_dup_ovr_o = sdup_q;
  assign lock_err_o   = err_q;
endmodule

// File: rtl/cvt_cfg_bank_chk.sv
module cvt_cfg_bank_chk
  import cvt_cfg_pkg::*;
#(
  parameter int unsigned NPORT  = 5,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [MODE_W-1:0] sw_mode_o,
  input logic [NPORT-1:0]  port_run_o,
  input logic              lock_err_o,
  input logic              unlocked
);
  logic mode_wr, run_wr;
  assign mode_wr = wr_i && addr_i == ADDR_W'(OFF_MODE);
  assign run_wr  = wr_i && addr_i == ADDR_W'(OFF_RUN);

  p_unlock_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlocked |=> unlocked);

  p_locked_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr && !unlocked |=> $stable(sw_mode_o) && lock_err_o);

  p_err_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_err_o |=> lock_err_o);

  p_mode_land_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr && unlocked |=> sw_mode_o == $past(wdata_i[MODE_W-1:0]));

  p_run_land_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_wr |=> port_run_o == $past(wdata_i[NPORT-1:0]));

  p_unmapped_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i[ADDR_W-1:10] != '0 |=> rdata_o == '0);
endmodule

bind cvt_cfg_bank cvt_cfg_bank_chk #(.NPORT(NPORT), .ADDR_W(ADDR_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wr_i       (wr_i),
  .wdata_i    (wdata_i),
  .rd_i       (rd_i),
  .rdata_o    (rdata_o),
  .sw_mode_o  (sw_mode_o),
  .port_run_o (port_run_o),
  .lock_err_o (lock_err_o),
  .unlocked   (unlocked)
);

// File: tb/cvt_cfg_bank_tb_top.sv
module cvt_cfg_bank_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic        wr_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        rd_i = 1'b0;
  logic [31:0] rdata_o;
  logic [4:0]  rgmii_link_i = '0;
  logic [4:0]  rgmii_dup_i = '0;
  logic [9:0]  rgmii_spd_i = '0;
  logic [4:0]  sw_mode_o;
  logic [9:0]  port_speed_o, port_if_o;
  logic [4:0]  port_fdx_o, port_run_o, sw_spd_ovr_o, sw_dup_ovr_o;
  logic        lock_err_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  cvt_cfg_bank dut_i (.*);

  // {addr, write value, expected readback}
  localparam int NV = 10;
  localparam logic [75:0] VEC [NV] = '{
    {12'h020, 32'h0000_0013, 32'h0000_0013},  // R5
    {12'h020, 32'hFFFF_FFE9, 32'h0000_0009},  // R5 upper bits dropped
    {12'h100, 32'h0000_0106, 32'h0000_0106},  // R6
    {12'h104, 32'hFFFF_FFFF, 32'h0000_010F},  // R6 R7 status bits not stored
    {12'h108, 32'h0000_0009, 32'h0000_0009},  // R6
    {12'h114, 32'h0000_0015, 32'h0000_0015},  // R8
    {12'h304, 32'h0000_001F, 32'h0000_001F},  // R9
    {12'h308, 32'h0000_0003, 32'h0000_0003},  // R9
    {12'h200, 32'hDEAD_BEEF, 32'h0000_0000},  // R10 unmapped
    {12'h000, 32'h0000_1234, 32'h0000_0000}   // R10 command reads 0
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 sw_mode", 32'(sw_mode_o), 0);
    chk("R1 port_run", 32'(port_run_o), 0);
    chk("R1 lock_err", 32'(lock_err_o), 0);
    chk("R1 port cfg", {port_speed_o, port_if_o, port_fdx_o}, 0);
    chk("R1 overrides", {sw_spd_ovr_o, sw_dup_ovr_o}, 0);

    // R4 locked write dropped
    wr(12'h020, 32'h5);
    chk("R4 locked mode", 32'(sw_mode_o), 0);
    chk("R4 err set", 32'(lock_err_o), 1);

    // R3 broken key resets tracker
    wr(12'h000, 32'h00A5); wr(12'h000, 32'h0001); wr(12'h000, 32'hFFFE);
    wr(12'h000, 32'h0002); wr(12'h000, 32'h0001);
    wr(12'h020, 32'h7);
    chk("R3 broken key stays locked", 32'(sw_mode_o), 0);

    // R3 interleaved other write; R2 unlock and immediate landing
    wr(12'h000, 32'h00A5); wr(12'h304, 32'h1); wr(12'h000, 32'h0001);
    wr(12'h000, 32'hFFFE);
    @(negedge clk_i);
    addr_i = 12'h000; wdata_i = 32'h0001; wr_i = 1'b1;
    @(negedge clk_i);
    addr_i = 12'h020; wdata_i = 32'h000C;
    @(negedge clk_i);
    wr_i = 1'b0;
    chk("R2 R3 unlocked next cycle", 32'(sw_mode_o), 32'hC);
    chk("R4 err sticky", 32'(lock_err_o), 1);

    // table walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][75:64], VEC[i][63:32]);
      rd(VEC[i][75:64], r);
      chk($sformatf("table %0d addr 0x%0h (R5 R6 R8 R9 R10)", i, VEC[i][75:64]), r, VEC[i][31:0]);
    end

    // R6 R8 R9 R5 outputs
    chk("R6 port0", {port_speed_o[1:0], port_if_o[1:0], 3'b0, port_fdx_o[0]}, {2'd2, 2'd1, 4'd1});
    chk("R6 port1", {port_speed_o[3:2], port_if_o[3:2], 3'b0, port_fdx_o[1]}, {2'd3, 2'd3, 4'd1});
    chk("R6 port4 untouched", {port_speed_o[9:8], port_if_o[9:8], port_fdx_o[4]}, 0);
    chk("R8 run", 32'(port_run_o), 32'h15);
    chk("R9 spd ovr", 32'(sw_spd_ovr_o), 32'h1F);
    chk("R9 dup ovr", 32'(sw_dup_ovr_o), 32'h3);
    chk("R5 mode out", 32'(sw_mode_o), 32'h9);

    // R7 status bits from pins, writes ignored
    rgmii_link_i[2] = 1'b1; rgmii_dup_i[2] = 1'b1; rgmii_spd_i[5:4] = 2'b10;
    rd(12'h108, r);
    chk("R7 status read", r, 32'h0000_B009);
    wr(12'h108, 32'h0000_0009);
    rgmii_link_i = '0; rgmii_dup_i = '0; rgmii_spd_i = '0;
    rd(12'h108, r);
    chk("R7 status live", r, 32'h0000_0009);
    // R10 hold between reads
    @(negedge clk_i); addr_i = 12'h114;
    @(negedge clk_i);
    chk("R10 hold", rdata_o, 32'h9);

    // R1 R2 relock after reset
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    chk("R1 err cleared", 32'(lock_err_o), 0);
    chk("R1 run cleared", 32'(port_run_o), 0);
    wr(12'h020, 32'h3);
    chk("R2 relocked after reset", 32'(sw_mode_o), 0);

    done = 1'b1;
    summary();
  end
endmodule